// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block feeds a transmit path from a ring of 8-byte descriptors held in system memory. Software loads a base pointer, fills descriptors and buffers, and raises a start pulse (or an external trigger pin). The engine then reads each descriptor over a single-word memory port, fetches the buffer it names and emits its contents one byte per cycle, with a start marker on the first byte and an end marker on the last byte of each frame. A frame may be gathered from several buffers.

The engine runs until it reads a descriptor that software still owns, and it stops there. It does nothing more until the next start pulse. When a frame's last buffer has been streamed, the engine returns the frame to software by setting the ownership bit in the frame's first descriptor. A frame that needs more buffers than the configured limit is dropped with an error flag.

Top module: `txd_ring_fetch`

## Requirements
- R1: After reset the engine is halted (`halted`=1), makes no memory request, emits no byte, and `err_limit` is 0.
- R2: A descriptor is two 32-bit words at pointer P (word 0) and P+4 (word 1). In word 0, bits 31:2 give the word-aligned buffer address, bit 1 is the wrap flag, and bit 0 is ignored. In word 1, bit 31 is the used flag, bit 15 marks the last buffer of a frame, and bits 13:0 give the byte length.
- R3: While `tx_enable` is 1, a one-cycle pulse on `tx_start` or on `tx_trigger` makes a halted engine fetch from its current descriptor pointer. Reading a descriptor with used=1 halts the engine (`halted`=1).
- R4: Buffer bytes are emitted in address order. Byte k of a word is bits 8k+7:8k. `out_sof` is set on the first byte of a frame and `out_eof` on the last byte. A frame's bytes are the concatenation of its buffers.
- R5: After a descriptor with the wrap flag set, the next descriptor is read at the base pointer. Otherwise it is read at the current pointer plus 8.
- R6: After the last buffer of a frame has been streamed, word 1 of the frame's first descriptor is written back with bit 31 set and all other bits unchanged. No other descriptor is written.
- R7: A zero-length buffer adds no bytes. When it is the last buffer of a frame, `out_eof` goes on the final byte of the preceding buffer.
- R8: A frame may use up to MAX_BUFS (128) buffers, zero-length ones included. If a frame reaches a further descriptor with used=0, the engine sets `err_limit`, halts, drops the frame, and writes no used bit. The next start pulse clears `err_limit`.
- R9: While `tx_enable` is 0, start pulses and trigger pulses are ignored: the engine stays halted and issues no memory request. Dropping `tx_enable` while running halts the engine on the next cycle.
- R10: A write on `qptr_we` always loads the base pointer. While halted it also loads the current descriptor pointer, so the next start fetches from the new base.
- R11: After a halt on a used descriptor, the next start fetches that same descriptor again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Engine enable level |
| tx_start | input | 1 | Software start pulse |
| tx_trigger | input | 1 | External start pulse |
| qptr_we | input | 1 | Queue base pointer write strobe |
| qptr_wdata | input | 32 | Queue base pointer value |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completion |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| halted | output | 1 | Engine is stopped |
| err_limit | output | 1 | Last frame exceeded the buffer limit |

## Verification
The bench builds a three-buffer frame with a zero-length middle buffer, and a second frame that wraps back to a descriptor the engine has just handed back. A design that miscounts bytes or skips the wrap would emit extra or missing bytes, or would run past the ring. A frame whose last buffer is empty checks that the end marker moves back to the previous byte; a design without a one-byte hold stage would lose that marker. The bench also places frames of exactly 128 and 129 buffers at the limit, where an off-by-one either rejects a legal frame or writes back the used bit of a dropped frame. Pulses sent while the engine is disabled must leave the memory port silent.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int PTR_W = 32;
  localparam int LEN_W = 14;

  typedef struct packed {
    logic [PTR_W-1:0] addr;
    logic             wrap;
    logic             used;
    logic             last;
    logic [LEN_W-1:0] len;
  } txd_desc_t;

  // Split the two descriptor words into fields (R2).
  function automatic txd_desc_t txd_decode(input logic [31:0] w0, input logic [31:0] w1);
    txd_desc_t d;
    d.addr = {w0[31:2], 2'b00};
    d.wrap = w0[1];
    d.used = w1[31];
    d.last = w1[15];
    d.len  = w1[LEN_W-1:0];
    return d;
  endfunction

  // Pointer of the descriptor that follows the current one (R5).
  function automatic logic [PTR_W-1:0] txd_next_ptr(input logic [PTR_W-1:0] cur,
                                                    input logic [PTR_W-1:0] base,
                                                    input logic wrap);
    return wrap ? base : cur + PTR_W'(8);
  endfunction

  // Little-endian byte lane select (R4).
  function automatic logic [7:0] txd_pick_byte(input logic [31:0] w, input logic [1:0] sel);
    logic [31:0] s;
    s = w >> {sel, 3'b000};
    return s[7:0];
  endfunction

  // Value written back to hand a descriptor back to software (R6).
  function automatic logic [31:0] txd_mark_used(input logic [31:0] w1);
    return w1 | 32'h8000_0000;
  endfunction
endpackage

// File: rtl/txd_buf_count.sv
module txd_buf_count #(
  parameter int MAX_BUFS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit,
  output logic is_zero
);
  localparam int CW = $clog2(MAX_BUFS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + CW'(1);
  end

  assign at_limit = (cnt == CW'(MAX_BUFS));
  assign is_zero  = (cnt == '0);

  AST_NO_ACCEPT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit); // R8
endmodule

// File: rtl/txd_byte_hold.sv
module txd_byte_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_byte,
  input  logic       close,
  input  logic       drop,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_sof,
  output logic       out_eof
);
  logic       hv;
  logic [7:0] hb;
  logic       hs;
  logic       started;

  // One byte is held back so that the end marker can land on it once the
  // frame's last descriptor (possibly empty) has been seen (R7).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv <= 1'b0; hb <= '0; hs <= 1'b0; started <= 1'b0;
      out_valid <= 1'b0; out_byte <= '0; out_sof <= 1'b0; out_eof <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      if (drop) begin
        hv <= 1'b0; started <= 1'b0;
      end else if (push) begin
        if (hv) begin
          out_valid <= 1'b1; out_byte <= hb; out_sof <= hs;
        end
        hv <= 1'b1; hb <= push_byte; hs <= !started; started <= 1'b1;
      end else if (close) begin
        if (hv) begin
          out_valid <= 1'b1; out_byte <= hb; out_sof <= hs; out_eof <= 1'b1;
        end
        hv <= 1'b0; started <= 1'b0;
      end
    end
  end

  AST_PUSH_CLOSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && close)); // R4
  AST_EOF_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> $past(close)); // R4
endmodule

// File: rtl/txd_ring_fetch.sv
module txd_ring_fetch
  import txd_pkg::*;
#(
  parameter int MAX_BUFS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_enable,
  input  logic        tx_start,
  input  logic        tx_trigger,
  input  logic        qptr_we,
  input  logic [31:0] qptr_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  output logic        out_sof,
  output logic        out_eof,
  output logic        halted,
  output logic        err_limit
);
  typedef enum logic [2:0] {S_IDLE, S_W0, S_W1, S_DREQ, S_EMIT, S_NEXT, S_WB} st_t;
  st_t state;

  logic [PTR_W-1:0] base, cur, nxt, first_ptr, baddr;
  logic [31:0]      w0_q, first_w1, word_q;
  logic [LEN_W-1:0] off, rem;
  logic             last_q;
  logic             at_limit, cnt_zero;
  txd_desc_t        desc_now;

  // Named internal events
  logic go, ev_used_halt, ev_overflow, ev_accept, ev_frame_done, ev_push, ev_close;

  assign desc_now      = txd_decode(w0_q, mem_rdata);
  assign go            = tx_enable && (tx_start || tx_trigger);
  assign ev_used_halt  = tx_enable && state == S_W1 && mem_ack && desc_now.used;
  assign ev_overflow   = tx_enable && state == S_W1 && mem_ack && !desc_now.used && at_limit;
  assign ev_accept     = tx_enable && state == S_W1 && mem_ack && !desc_now.used && !at_limit;
  assign ev_frame_done = tx_enable && state == S_WB && mem_ack;
  assign ev_push       = tx_enable && state == S_EMIT;
  assign ev_close      = tx_enable && state == S_NEXT && last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; base <= '0; cur <= '0; nxt <= '0; first_ptr <= '0;
      first_w1 <= '0; w0_q <= '0; word_q <= '0; baddr <= '0;
      off <= '0; rem <= '0; last_q <= 1'b0; err_limit <= 1'b0;
    end else begin
      if (qptr_we) base <= qptr_wdata;
      if (!tx_enable) begin
        state <= S_IDLE;
        if (state == S_IDLE && qptr_we) cur <= qptr_wdata;
      end else begin
        unique case (state)
          S_IDLE: begin
            if (qptr_we) cur <= qptr_wdata;
            if (go) begin err_limit <= 1'b0; state <= S_W0; end
          end
          S_W0: if (mem_ack) begin w0_q <= mem_rdata; state <= S_W1; end
          S_W1: if (mem_ack) begin
            if (desc_now.used) state <= S_IDLE;
            else if (at_limit) begin err_limit <= 1'b1; state <= S_IDLE; end
            else begin
              if (cnt_zero) begin first_ptr <= cur; first_w1 <= mem_rdata; end
              baddr  <= desc_now.addr;
              rem    <= desc_now.len;
              off    <= '0;
              last_q <= desc_now.last;
              nxt    <= txd_next_ptr(cur, base, desc_now.wrap);
              state  <= (desc_now.len == '0) ? S_NEXT : S_DREQ;
            end
          end
          S_DREQ: if (mem_ack) begin word_q <= mem_rdata; state <= S_EMIT; end
          S_EMIT: begin
            off <= off + LEN_W'(1);
            rem <= rem - LEN_W'(1);
            if (rem == LEN_W'(1))      state <= S_NEXT;
            else if (off[1:0] == 2'd3) state <= S_DREQ;
          end
          S_NEXT: begin
            cur   <= nxt;
            state <= last_q ? S_WB : S_W0;
          end
          S_WB: if (mem_ack) state <= S_W0;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = txd_mark_used(first_w1);
    unique case (state)
      S_W0:   begin mem_req = 1'b1; mem_addr = cur; end
      S_W1:   begin mem_req = 1'b1; mem_addr = cur + PTR_W'(4); end
      S_DREQ: begin mem_req = 1'b1; mem_addr = baddr + {{(PTR_W-LEN_W){1'b0}}, off[LEN_W-1:2], 2'b00}; end
      S_WB:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = first_ptr + PTR_W'(4); end
      default: ;
    endcase
  end

  assign halted = (state == S_IDLE);

  txd_buf_count #(.MAX_BUFS(MAX_BUFS)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(ev_overflow || ev_frame_done), .inc(ev_accept),
    .at_limit(at_limit), .is_zero(cnt_zero)
  );

  txd_byte_hold u_hold (
    .clk(clk), .rst_n(rst_n),
    .push(ev_push), .push_byte(txd_pick_byte(word_q, off[1:0])),
    .close(ev_close), .drop(ev_overflow),
    .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof), .out_eof(out_eof)
  );

  AST_USED_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_used_halt |=> halted); // R3
  AST_ERR_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    err_limit |-> halted); // R8
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> !mem_req); // R9
  AST_WB_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |=> cnt_zero); // R6
endmodule

// File: tb/txd_ring_fetch_tb.sv
module txd_ring_fetch_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_enable = 1'b0, tx_start = 1'b0, tx_trigger = 1'b0, qptr_we = 1'b0;
  logic [31:0] qptr_wdata = '0;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic out_valid, out_sof, out_eof, halted, err_limit;
  logic [7:0] out_byte;

  int total = 0, bad = 0, wr_cnt = 0, rd_cnt = 0;
  bit done = 0;

  logic [31:0] mem [0:4095];
  logic        tb_we = 1'b0;
  logic [31:0] tb_wa = '0, tb_wd = '0;

  logic [9:0] exp_q [$];   // {sof, eof, byte}
  logic [7:0] frame_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_ring_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_start(tx_start),
    .tx_trigger(tx_trigger), .qptr_we(qptr_we), .qptr_wdata(qptr_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .out_valid(out_valid),
    .out_byte(out_byte), .out_sof(out_sof), .out_eof(out_eof),
    .halted(halted), .err_limit(err_limit)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + (a >> 5)) & 255);
  endfunction

  // Memory model: single writer process, one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < 4096; i++)
        mem[i] <= {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin mem[mem_addr[13:2]] <= mem_wdata; wr_cnt++; end
        else begin mem_rdata <= mem[mem_addr[13:2]]; rd_cnt++; end
      end
      if (tb_we) mem[tb_wa[13:2]] <= tb_wd;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as bytes appear (R4)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {22'b0, out_sof, out_eof, out_byte}, 32'h0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({out_sof, out_eof, out_byte} == e, "R4 stream byte",
            {22'b0, out_sof, out_eof, out_byte}, {22'b0, e});
      end
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] base, input int idx, input logic [31:0] baddr,
                          input bit wrap, input bit used, input bit last, input int len,
                          input bit b0);
    poke(base + 32'(idx*8), {baddr[31:2], wrap, b0});
    poke(base + 32'(idx*8) + 4, {used, 15'b0, last, 1'b0, 14'(len)});
  endtask

  function automatic logic [31:0] w1_of(input logic [31:0] base, input int idx);
    return mem[(base + 32'(idx*8) + 4) >> 2];
  endfunction

  task automatic add_buf(input logic [31:0] baddr, input int len);
    for (int i = 0; i < len; i++) frame_q.push_back(pat(int'(baddr) + i));
  endtask

  task automatic end_frame();
    int n;
    n = frame_q.size();
    for (int i = 0; i < n; i++) exp_q.push_back({(i == 0), (i == n-1), frame_q[i]});
    frame_q.delete();
  endtask

  task automatic set_qptr(input logic [31:0] p);
    qptr_we = 1'b1; qptr_wdata = p;
    @(negedge clk);
    qptr_we = 1'b0;
  endtask

  task automatic kick(input bit use_trig);
    if (use_trig) tx_trigger = 1'b1; else tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0; tx_trigger = 1'b0;
  endtask

  task automatic wait_halt();
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    while (!halted && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] orig, w0c, rdc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(halted == 1'b1, "R1 halted", {31'b0, halted}, 32'h1);
    chk(mem_req == 1'b0, "R1 mem_req", {31'b0, mem_req}, 32'h0);
    chk(out_valid == 1'b0, "R1 out_valid", {31'b0, out_valid}, 32'h0);
    chk(err_limit == 1'b0, "R1 err_limit", {31'b0, err_limit}, 32'h0);

    // Single-buffer frame, then a used descriptor (R2, R3, R6, R10)
    set_desc(32'h0, 0, 32'h3000, 0, 0, 1, 5, 0);
    set_desc(32'h0, 1, 32'h3100, 0, 1, 0, 3, 0);
    set_qptr(32'h0);
    orig = w1_of(32'h0, 0);
    add_buf(32'h3000, 5); end_frame();
    tx_enable = 1'b1;
    kick(0);
    wait_halt();
    chk(halted == 1'b1, "R3 halt on used", {31'b0, halted}, 32'h1);
    chk(exp_q.size() == 0, "R4 all bytes seen", 32'(exp_q.size()), 32'h0);
    chk(w1_of(32'h0, 0) == (orig | 32'h8000_0000), "R6 writeback", w1_of(32'h0, 0), orig | 32'h8000_0000);
    chk(w1_of(32'h0, 1) == 32'h8000_0003, "R6 used desc untouched", w1_of(32'h0, 1), 32'h8000_0003);
    chk(wr_cnt == 1, "R6 one write", 32'(wr_cnt), 32'h1);

    // Gather with empty middle buffer, then wrapping frame; restart at the
    // halted descriptor (R4, R5, R7, R11, R2 bit0 ignored)
    set_desc(32'h0, 1, 32'h3100, 0, 0, 0, 3, 0);
    set_desc(32'h0, 2, 32'h3200, 0, 0, 0, 0, 0);
    set_desc(32'h0, 3, 32'h3300, 0, 0, 1, 6, 1);
    set_desc(32'h0, 4, 32'h3400, 1, 0, 1, 4, 0);
    add_buf(32'h3100, 3); add_buf(32'h3300, 6); end_frame();
    add_buf(32'h3400, 4); end_frame();
    kick(1);
    wait_halt();
    chk(exp_q.size() == 0, "R4 gathered frames", 32'(exp_q.size()), 32'h0);
    chk(w1_of(32'h0, 1)[31] == 1'b1, "R6 first desc marked", w1_of(32'h0, 1), 32'h8000_0003);
    chk(w1_of(32'h0, 2)[31] == 1'b0, "R6 middle not marked", w1_of(32'h0, 2), 32'h0);
    chk(w1_of(32'h0, 3)[31] == 1'b0, "R6 last not marked", w1_of(32'h0, 3), 32'h8006);
    chk(w1_of(32'h0, 4)[31] == 1'b1, "R5 wrap frame marked", w1_of(32'h0, 4), 32'h8000_8004);
    chk(wr_cnt == 3, "R5 halted at base after wrap", 32'(wr_cnt), 32'h3);
    set_desc(32'h0, 0, 32'h3500, 0, 0, 1, 7, 0);
    add_buf(32'h3500, 7); end_frame();
    kick(0);
    wait_halt();
    chk(exp_q.size() == 0, "R11 resumed at base desc", 32'(exp_q.size()), 32'h0);
    chk(w1_of(32'h0, 0)[31] == 1'b1, "R11 base desc marked", w1_of(32'h0, 0), 32'h8000_8007);

    // Empty last buffer; new base while halted (R7, R10)
    set_desc(32'h800, 0, 32'h3600, 0, 0, 0, 2, 0);
    set_desc(32'h800, 1, 32'h3700, 0, 0, 1, 0, 0);
    set_desc(32'h800, 2, 32'h3700, 0, 1, 0, 0, 0);
    set_qptr(32'h800);
    add_buf(32'h3600, 2); end_frame();
    kick(0);
    wait_halt();
    chk(exp_q.size() == 0, "R7 eof on earlier byte", 32'(exp_q.size()), 32'h0);
    chk(w1_of(32'h800, 0) == 32'h8000_0002, "R10 new ring written", w1_of(32'h800, 0), 32'h8000_0002);
    chk(w1_of(32'h800, 1) == 32'h0000_8000, "R7 empty last untouched", w1_of(32'h800, 1), 32'h8000);

    // Disabled: pulses ignored (R9)
    tx_enable = 1'b0;
    w0c = 32'(wr_cnt); rdc = 32'(rd_cnt);
    kick(0); kick(1);
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R9 stays halted", {31'b0, halted}, 32'h1);
    chk(32'(rd_cnt) == rdc && 32'(wr_cnt) == w0c, "R9 no memory traffic", 32'(rd_cnt), rdc);
    tx_enable = 1'b1;

    // Exactly MAX_BUFS buffers (R8)
    for (int i = 0; i < 127; i++) set_desc(32'h1000, i, 32'h3800, 0, 0, 0, 0, 0);
    set_desc(32'h1000, 127, 32'h3800, 0, 0, 1, 3, 0);
    set_desc(32'h1000, 128, 32'h3800, 0, 1, 0, 0, 0);
    set_qptr(32'h1000);
    add_buf(32'h3800, 3); end_frame();
    kick(0);
    wait_halt();
    chk(exp_q.size() == 0, "R8 128 buffers streamed", 32'(exp_q.size()), 32'h0);
    chk(err_limit == 1'b0, "R8 no error at limit", {31'b0, err_limit}, 32'h0);
    chk(w1_of(32'h1000, 0) == 32'h8000_0000, "R8 limit frame marked", w1_of(32'h1000, 0), 32'h8000_0000);

    // One buffer too many (R8)
    for (int i = 0; i < 129; i++) set_desc(32'h2000, i, 32'h3900, 0, 0, 0, 0, 0);
    set_desc(32'h2000, 129, 32'h3900, 0, 1, 0, 0, 0);
    set_qptr(32'h2000);
    w0c = 32'(wr_cnt);
    kick(0);
    wait_halt();
    chk(err_limit == 1'b1, "R8 error raised", {31'b0, err_limit}, 32'h1);
    chk(halted == 1'b1, "R8 halted on error", {31'b0, halted}, 32'h1);
    chk(w1_of(32'h2000, 0)[31] == 1'b0 && 32'(wr_cnt) == w0c, "R8 no writeback", w1_of(32'h2000, 0), 32'h0);
    set_desc(32'h2000, 128, 32'h3900, 0, 1, 0, 0, 0);
    kick(0);
    wait_halt();
    chk(err_limit == 1'b0, "R8 start clears error", {31'b0, err_limit}, 32'h0);
    chk(exp_q.size() == 0, "R8 dropped frame emits nothing", 32'(exp_q.size()), 32'h0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule